// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Controller

This block gathers single-cycle event pulses from the transmit and receive paths of an Ethernet MAC. Each pulse sets a sticky bit in a 32-bit status register, and that bit stays set until software clears it by writing a one to it. A second 32-bit enable register masks the status bits. The enabled status bits feed two interrupt outputs: one for the transmit group and one for the receive group. A simple register port lets software read and write both registers. Reads are combinational from the selected register.

A small state machine also holds the transmit DMA halted after two fatal transmit events. It has three states:
- `TXQ_RUN`: the transmit DMA runs freely.
- `TXQ_WAIT_KICK`: entered on a descriptor-unavailable event. The transition back to `TXQ_RUN` happens when software pulses the start-demand strobe.
- `TXQ_LOCKED`: entered on a transmit bus error, from either of the other states. The only way out is a soft reset, which returns to `TXQ_RUN`.

A descriptor-unavailable event in `TXQ_WAIT_KICK` keeps the machine there. A late-collision status bit is qualified inside the block: it is set only when a collision is reported at or beyond a bit-time threshold of the frame.

Top module: `mac_irq_ctrl`

## Requirements
- R1: After `rst_n` is asserted, the status and enable registers read 0, and `tx_irq`, `rx_irq` and `tx_halt` are 0.
- R2: A pulse on `rx_evt[i]` (i = 0..14) sets status bit i, and `tx_evt[j]` (j = 0..8, j != 6) sets status bit 16+j. The update is visible on `reg_rdata` with `reg_sel`=0 after the next rising clock edge. Set bits stay set until cleared.
- R3: A write with `reg_sel`=0 clears every status bit whose `reg_wdata` bit is 1 and leaves every bit whose `reg_wdata` bit is 0 unchanged.
- R4: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Bits 31..25 and bit 15 read 0 in both registers, whatever is written and whatever events arrive.
- R6: A write with `reg_sel`=1 loads the enable register from `reg_wdata`, masked to the implemented bits. Reads with `reg_sel`=1 return it.
- R7: `tx_irq` is the OR of (status AND enable) over bits 24..16, and `rx_irq` is the same over bits 14..0. Clearing enable bits drops the interrupt but leaves the status unchanged.
- R8: Status bit 22 (late collision) is set only by `col_pulse` with `col_bitpos` >= 512. A collision below 512 sets nothing, and `tx_evt[6]` has no effect.
- R9: `tx_evt[7]` (descriptor unavailable) raises `tx_halt` from the next cycle. A `tx_kick` pulse then clears `tx_halt`. If the event and the kick arrive together, the event wins.
- R10: `tx_evt[8]` (transmit bus error) raises `tx_halt` from the next cycle, and it beats a same-cycle kick or descriptor event. Neither `tx_kick` nor a later descriptor event releases it.
- R11: `soft_rst` clears status, enable and `tx_halt` at the next edge, and it overrides any event or write in the same cycle.
- R12: `tx_halt` follows the R9 and R10 events whatever the enable bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous controller reset strobe |
| rx_evt | input | 15 | Receive event pulses, bit i to status bit i |
| tx_evt | input | 9 | Transmit event pulses, bit j to status bit 16+j (bit 6 unused) |
| col_pulse | input | 1 | Collision detected pulse |
| col_bitpos | input | 11 | Bit time of the frame at which the collision occurred |
| tx_kick | input | 1 | Transmit start-demand strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| tx_irq | output | 1 | Transmit group interrupt |
| rx_irq | output | 1 | Receive group interrupt |
| tx_halt | output | 1 | Transmit DMA halt |

## Verification
The bench builds the block with its default parameters:
- a 32-bit register width;
- 9 transmit and 15 receive event bits, with the transmit group starting at bit 16;
- an 11-bit collision position and a late threshold of 512.

Random collision positions in 0..1023 land on both sides of the threshold, and directed cases hit 511 and 512 exactly. Rare random bus-error and descriptor events, kicks and soft resets drive the halt machine through all three states and every transition. Each cycle also mixes events with same-cycle clears, so the set-over-clear priority is exercised under load.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;

    typedef enum logic [1:0] {
        TXQ_RUN       = 2'd0,
        TXQ_WAIT_KICK = 2'd1,
        TXQ_LOCKED    = 2'd2
    } txq_state_e;

endpackage

// File: rtl/mac_irq_latecol.sv
module mac_irq_latecol #(
    parameter int unsigned BITPOS_W      = 11,
    parameter int unsigned LATE_COL_BITS = 512
) (
    input  logic                col_pulse,
    input  logic [BITPOS_W-1:0] col_bitpos,
    output logic                late_evt
);
    localparam logic [BITPOS_W-1:0] LIMIT = BITPOS_W'(LATE_COL_BITS);

    // Only collisions past the slot window count as late.
    always_comb begin
        late_evt = col_pulse && (col_bitpos >= LIMIT);
    end
endmodule

// File: rtl/mac_irq_regbank.sv
module mac_irq_regbank #(
    parameter int unsigned       DATA_W    = 32,
    parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [DATA_W-1:0] set_vec,
    input  logic [DATA_W-1:0] clr_vec,
    input  logic              en_wr,
    input  logic [DATA_W-1:0] en_wdata,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] enable_q
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            // Sticky status bit: a set beats a same-cycle clear.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    status_q[i] <= 1'b0;
                end else if (soft_rst) begin
                    status_q[i] <= 1'b0;
                end else if (set_vec[i]) begin
                    status_q[i] <= 1'b1;
                end else if (clr_vec[i]) begin
                    status_q[i] <= 1'b0;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    enable_q[i] <= 1'b0;
                end else if (soft_rst) begin
                    enable_q[i] <= 1'b0;
                end else if (en_wr) begin
                    enable_q[i] <= en_wdata[i];
                end
            end
        end else begin : g_rsvd
            logic unused_rsvd;
            assign unused_rsvd = set_vec[i] ^ clr_vec[i] ^ en_wdata[i];
            assign status_q[i] = 1'b0;
            assign enable_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/mac_irq_txq_fsm.sv
module mac_irq_txq_fsm
    import mac_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic desc_evt,
    input  logic bus_evt,
    input  logic kick,
    output logic tx_halt,
    output logic halt_bus
);
    txq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TXQ_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = TXQ_RUN;
        end else begin
            unique case (state_q)
                TXQ_RUN: begin
                    if (bus_evt) begin
                        state_d = TXQ_LOCKED;
                    end else if (desc_evt) begin
                        state_d = TXQ_WAIT_KICK;
                    end
                end
                TXQ_WAIT_KICK: begin
                    if (bus_evt) begin
                        state_d = TXQ_LOCKED;
                    end else if (desc_evt) begin
                        state_d = TXQ_WAIT_KICK;
                    end else if (kick) begin
                        state_d = TXQ_RUN;
                    end
                end
                TXQ_LOCKED: begin
                    state_d = TXQ_LOCKED;
                end
                default: begin
                    state_d = TXQ_RUN;
                end
            endcase
        end
    end

    always_comb begin
        tx_halt  = 1'b0;
        halt_bus = 1'b0;
        unique case (state_q)
            TXQ_RUN:       tx_halt = 1'b0;
            TXQ_WAIT_KICK: tx_halt = 1'b1;
            TXQ_LOCKED: begin
                tx_halt  = 1'b1;
                halt_bus = 1'b1;
            end
            default:       tx_halt = 1'b0;
        endcase
    end
endmodule

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl #(
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned RX_BITS       = 15,
    parameter int unsigned TX_BITS       = 9,
    parameter int unsigned TX_LSB        = 16,
    parameter int unsigned BITPOS_W      = 11,
    parameter int unsigned LATE_COL_BITS = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic [RX_BITS-1:0]  rx_evt,
    input  logic [TX_BITS-1:0]  tx_evt,
    input  logic                col_pulse,
    input  logic [BITPOS_W-1:0] col_bitpos,
    input  logic                tx_kick,
    input  logic                reg_wr,
    input  logic                reg_sel,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                tx_irq,
    output logic                rx_irq,
    output logic                tx_halt
);
    localparam int unsigned LATE_OFS = 6;
    localparam int unsigned DESC_OFS = 7;
    localparam int unsigned BUS_OFS  = 8;
    localparam logic [DATA_W-1:0] RX_MASK   = DATA_W'((64'd1 << RX_BITS) - 64'd1);
    localparam logic [DATA_W-1:0] TX_MASK   = DATA_W'(((64'd1 << TX_BITS) - 64'd1) << TX_LSB);
    localparam logic [DATA_W-1:0] IMPL_MASK = RX_MASK | TX_MASK;

    logic                late_evt;
    logic [DATA_W-1:0]   set_vec;
    logic [DATA_W-1:0]   clr_vec;
    logic [DATA_W-1:0]   status_q;
    logic [DATA_W-1:0]   enable_q;
    logic                halt_bus;
    logic                en_wr;
    logic                unused_late_in;

    assign unused_late_in = tx_evt[LATE_OFS];

    mac_irq_latecol #(
        .BITPOS_W      (BITPOS_W),
        .LATE_COL_BITS (LATE_COL_BITS)
    ) u_latecol (
        .col_pulse  (col_pulse),
        .col_bitpos (col_bitpos),
        .late_evt   (late_evt)
    );

    // Event pulses placed at their status positions.
    always_comb begin
        set_vec = '0;
        set_vec[RX_BITS-1:0] = rx_evt;
        for (int j = 0; j < int'(TX_BITS); j++) begin
            if (j != int'(LATE_OFS)) begin
                set_vec[TX_LSB + j] = tx_evt[j];
            end
        end
        set_vec[TX_LSB + LATE_OFS] = late_evt;
    end

    always_comb begin
        clr_vec = (reg_wr && !reg_sel) ? (reg_wdata & IMPL_MASK) : '0;
        en_wr   = reg_wr && reg_sel;
    end

    mac_irq_regbank #(
        .DATA_W    (DATA_W),
        .IMPL_MASK (IMPL_MASK)
    ) u_regbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .en_wr    (en_wr),
        .en_wdata (reg_wdata),
        .status_q (status_q),
        .enable_q (enable_q)
    );

    mac_irq_txq_fsm u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .desc_evt (tx_evt[DESC_OFS]),
        .bus_evt  (tx_evt[BUS_OFS]),
        .kick     (tx_kick),
        .tx_halt  (tx_halt),
        .halt_bus (halt_bus)
    );

    always_comb begin
        reg_rdata = reg_sel ? enable_q : status_q;
        tx_irq    = |(status_q & enable_q & TX_MASK);
        rx_irq    = |(status_q & enable_q & RX_MASK);
    end
endmodule

// File: rtl/mac_irq_ctrl_chk.sv
module mac_irq_ctrl_chk #(
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned TX_BITS       = 9,
    parameter int unsigned TX_LSB        = 16,
    parameter int unsigned BITPOS_W      = 11,
    parameter int unsigned LATE_COL_BITS = 512
) (
    input logic                clk,
    input logic                rst_n,
    input logic                soft_rst,
    input logic [TX_BITS-1:0]  tx_evt,
    input logic                col_pulse,
    input logic [BITPOS_W-1:0] col_bitpos,
    input logic [DATA_W-1:0]   set_vec,
    input logic [DATA_W-1:0]   status_q,
    input logic [DATA_W-1:0]   enable_q,
    input logic                tx_irq,
    input logic                rx_irq,
    input logic                tx_halt,
    input logic                halt_bus
);
    localparam int unsigned LATE_IDX = TX_LSB + 6;
    localparam logic [BITPOS_W-1:0] LIMIT = BITPOS_W'(LATE_COL_BITS);

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((|set_vec) && !soft_rst) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[DATA_W-1:TX_LSB+TX_BITS] == '0) && (status_q[TX_LSB-1] == 1'b0)
        && (enable_q[DATA_W-1:TX_LSB+TX_BITS] == '0));

    a_r7_tx_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q[TX_LSB+TX_BITS-1:TX_LSB] == '0) |-> !tx_irq);

    a_r8_late_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_q[LATE_IDX] && !(col_pulse && (col_bitpos >= LIMIT))) |=> !status_q[LATE_IDX]);

    a_r9_desc_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_evt[7] && !soft_rst) |=> tx_halt);

    a_r10_bus_locked: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_evt[8] || halt_bus) && !soft_rst) |=> (halt_bus && tx_halt));

    a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ((status_q == '0) && !tx_halt && !tx_irq && !rx_irq));
endmodule

bind mac_irq_ctrl mac_irq_ctrl_chk #(
    .DATA_W        (DATA_W),
    .TX_BITS       (TX_BITS),
    .TX_LSB        (TX_LSB),
    .BITPOS_W      (BITPOS_W),
    .LATE_COL_BITS (LATE_COL_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .tx_evt     (tx_evt),
    .col_pulse  (col_pulse),
    .col_bitpos (col_bitpos),
    .set_vec    (set_vec),
    .status_q   (status_q),
    .enable_q   (enable_q),
    .tx_irq     (tx_irq),
    .rx_irq     (rx_irq),
    .tx_halt    (tx_halt),
    .halt_bus   (halt_bus)
);

// File: tb/mac_irq_ctrl_bench.sv
module mac_irq_ctrl_bench;
    localparam logic [31:0] IMPL = 32'h01FF_7FFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        soft_rst;
    logic [14:0] rx_evt;
    logic [8:0]  tx_evt;
    logic        col_pulse;
    logic [10:0] col_bitpos;
    logic        tx_kick;
    logic        reg_wr;
    logic        reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        tx_irq;
    logic        rx_irq;
    logic        tx_halt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] m_stat;
    logic [31:0] m_en;
    int          m_hs;

    always #5 clk = ~clk;

    mac_irq_ctrl u_mac_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_evt(rx_evt), .tx_evt(tx_evt),
        .col_pulse(col_pulse), .col_bitpos(col_bitpos), .tx_kick(tx_kick), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_irq(tx_irq),
        .rx_irq(rx_irq), .tx_halt(tx_halt)
    );

    function automatic logic [31:0] exp_set(logic [14:0] rx, logic [8:0] tx, logic col, logic [10:0] pos);
        logic [31:0] s;
        s = {16'h0, 1'b0, rx};
        s[24:16] = tx & 9'h1BF;
        if (col && pos >= 11'd512) s[22] = 1'b1;
        return s;
    endfunction

    function automatic void model_step();
        logic [31:0] clr;
        if (soft_rst) begin
            m_stat = '0; m_en = '0; m_hs = 0;
            return;
        end
        clr = (reg_wr && !reg_sel) ? (reg_wdata & IMPL) : '0;
        m_stat = (m_stat & ~clr) | exp_set(rx_evt, tx_evt, col_pulse, col_bitpos);
        if (reg_wr && reg_sel) m_en = reg_wdata & IMPL;
        if (tx_evt[8]) m_hs = 2;
        else if (m_hs < 2) begin
            if (tx_evt[7]) m_hs = 1;
            else if (tx_kick) m_hs = 0;
        end
    endfunction

    task automatic clear_inputs();
        soft_rst = 0; rx_evt = '0; tx_evt = '0; col_pulse = 0; col_bitpos = '0;
        tx_kick = 0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        reg_wr = 0;
        reg_sel = 0;
        #1 chk(req, "status", reg_rdata, m_stat);
        reg_sel = 1;
        #1 chk(req, "enable", reg_rdata, m_en);
        chk(req, "tx_irq", {31'h0, tx_irq}, {31'h0, |(m_stat[24:16] & m_en[24:16])});
        chk(req, "rx_irq", {31'h0, rx_irq}, {31'h0, |(m_stat[14:0] & m_en[14:0])});
        chk(req, "tx_halt", {31'h0, tx_halt}, {31'h0, m_hs != 0});
    endtask

    task automatic cyc(string req);
        @(posedge clk);
        model_step();
        #2;
        clear_inputs();
        check_all(req);
    endtask

    initial begin
        clear_inputs();
        rst_n = 0;
        m_stat = '0; m_en = '0; m_hs = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        check_all("R1");

        // R2: placement of receive and transmit events
        rx_evt = 15'h4081; tx_evt = 9'h005; cyc("R2");
        // R8: tx_evt[6] ignored, threshold at 511/512
        tx_evt = 9'h040; cyc("R8");
        col_pulse = 1; col_bitpos = 11'd511; cyc("R8");
        col_pulse = 1; col_bitpos = 11'd512; cyc("R8");
        // R6 / R5: enable write of all ones, reserved reads 0
        reg_wr = 1; reg_sel = 1; reg_wdata = 32'hFFFF_FFFF; cyc("R6");
        // R7: masking drops interrupts, keeps status
        reg_wr = 1; reg_sel = 1; reg_wdata = 32'h0; cyc("R7");
        reg_wr = 1; reg_sel = 1; reg_wdata = 32'h0000_4000; cyc("R7");
        // R3: partial clear
        reg_wr = 1; reg_sel = 0; reg_wdata = 32'h0000_0081; cyc("R3");
        // R4: set beats clear
        rx_evt = 15'h0002; reg_wr = 1; reg_sel = 0; reg_wdata = 32'h0000_0002; cyc("R4");
        // R9 and R12 (tx enables are 0)
        tx_evt = 9'h080; cyc("R9");
        cyc("R12");
        tx_kick = 1; cyc("R9");
        tx_evt = 9'h080; tx_kick = 1; cyc("R9");
        tx_kick = 1; cyc("R9");
        // R10: bus error lock
        tx_evt = 9'h180; tx_kick = 1; cyc("R10");
        tx_kick = 1; cyc("R10");
        tx_evt = 9'h080; cyc("R10");
        // R11: soft reset overrides events and writes
        soft_rst = 1; rx_evt = 15'h0001; reg_wr = 1; reg_sel = 1; reg_wdata = '1; cyc("R11");
        // R5: every event at once, then a write of ones to status
        rx_evt = 15'h7FFF; tx_evt = 9'h1FF; col_pulse = 1; col_bitpos = 11'd600; cyc("R5");
        reg_wr = 1; reg_sel = 0; reg_wdata = 32'hFE00_8000; cyc("R5");
        soft_rst = 1; cyc("R11");

        for (int k = 0; k < 3000; k++) begin
            rx_evt = 15'($urandom & $urandom & $urandom);
            tx_evt = 9'($urandom & $urandom) & 9'h07F;
            if ($urandom % 24 == 0) tx_evt[7] = 1'b1;
            if ($urandom % 60 == 0) tx_evt[8] = 1'b1;
            col_pulse  = ($urandom % 4 == 0);
            col_bitpos = 11'($urandom % 1024);
            tx_kick    = ($urandom % 6 == 0);
            soft_rst   = ($urandom % 90 == 0);
            reg_wr     = ($urandom % 3 == 0);
            reg_sel    = 1'($urandom);
            reg_wdata  = $urandom;
            cyc("R2/R3/R4/R7/R8/R9/R10/R11 random");
        end

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule